// File: doc/BRIEF.md
# Multiplexer-Folded Boolean Function Cell

This block realises any Boolean function of `NVARS` inputs with one multiplexer of `2^(NVARS-1)` inputs. The upper `NVARS-1` inputs drive the multiplexer select. The lowest input is left over as a data variable. Each multiplexer input holds a 2-bit residue code that picks one of four values for that row: constant 0, constant 1, the data variable, or the data variable inverted. Any pair of truth-table rows that share the select value always reduces to one of these four.

Residue codes are held in registers with a synchronous active-low reset. They can be written one row at a time through a configuration port. They can also all be derived in one clock cycle from a full `2^NVARS`-bit truth table. Once the cell is configured, the output is purely combinational from the variable inputs. `NVARS` may range from 2 to 6.

Top module: `mux_fn_cell`

## Requirements
- R1: A clock edge with `rst_n` low sets every residue to constant 0. After that, `f_out` is 0 for every value of `vars_in`.
- R2: `vars_in[NVARS-1]` is the first (most significant) variable and `vars_in[0]` is the data variable. Bits `vars_in[NVARS-1:1]` form the row index k. The minterm index equals the value of `vars_in`, so minterm m is served by row m>>1.
- R3: The residue code of the selected row sets `f_out` as follows: 2'b00 gives 0, 2'b01 gives 1, 2'b10 gives `vars_in[0]`, and 2'b11 gives `~vars_in[0]`.
- R4: With `cfg_we` high and `tt_we` low, a clock edge writes `cfg_code` into row `cfg_row` and leaves every other row unchanged.
- R5: With `tt_we` high, a clock edge loads every row from `tt_bits`, where bit i is the function value at minterm i. Row k takes the pair (bit 2k, bit 2k+1) and maps it as follows: (0,0) gives 2'b00, (1,1) gives 2'b01, (0,1) gives 2'b10, and (1,0) gives 2'b11. As a result, `f_out` equals `tt_bits[vars_in]`.
- R6: When `tt_we` and `cfg_we` are high in the same cycle, the truth-table load wins and `cfg_code` is discarded.
- R7: With both write enables low, the residues hold their values across clock edges. `f_out` follows changes on `vars_in` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the residue registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Write one residue row |
| cfg_row | input | NVARS-1 | Row addressed by `cfg_we` |
| cfg_code | input | 2 | Residue code to write |
| tt_we | input | 1 | Load all rows from a truth table |
| tt_bits | input | 2^NVARS | Truth table, bit i is the function value at minterm i |
| vars_in | input | NVARS | Function variables; bit 0 is the data variable |
| f_out | output | 1 | Function value |

## Verification
The bench loads asymmetric truth tables and sweeps every minterm. A design that folded onto the wrong variable, or swapped the two rows of a pair, would mix up the data-variable and inverted residues, and some minterms would read back wrong. Single-row writes are followed by a full sweep, so a write that spilled into a neighbouring row, or landed on the wrong row, shows up as a stray output. A cycle where both write enables are high checks that the truth-table load takes priority. A reset after a full load of ones checks that every row is cleared and not only some of them. The three-variable worked example m0+m2+m6+m7 is also checked, which exercises both complemented rows.

// File: rtl/mfc_pkg.sv
// Package: shared residue encoding and helpers for the function cell.
// Assumes a residue is two bits and that a row pair is (data var = 0, data var = 1).
package mfc_pkg;

    typedef enum logic [1:0] {
        RES_ZERO   = 2'b00,
        RES_ONE    = 2'b01,
        RES_DATA   = 2'b10,
        RES_DATA_N = 2'b11
    } residue_e;

    // Reduce two truth-table rows (data var 0, data var 1) to a residue.
    function automatic residue_e fold_pair(input logic at0, input logic at1);
        case ({at0, at1})
            2'b00:   return RES_ZERO;
            2'b11:   return RES_ONE;
            2'b01:   return RES_DATA;
            default: return RES_DATA_N;
        endcase
    endfunction

    // Evaluate a residue against the data variable.
    function automatic logic eval_residue(input logic [1:0] code, input logic dvar);
        case (code)
            RES_ZERO:   return 1'b0;
            RES_ONE:    return 1'b1;
            RES_DATA:   return dvar;
            default:    return ~dvar;
        endcase
    endfunction

endpackage

// File: rtl/mfc_tt_fold.sv
// Module: derives one residue per row from a full truth table.
// Assumes bit i of the table is the function at minterm i; purely combinational.
module mfc_tt_fold #(
    parameter int NVARS = 4
) (
    input  logic [(2**NVARS)-1:0]       tt_bits,
    output logic [2*(2**(NVARS-1))-1:0] folded
);
    import mfc_pkg::*;

    localparam int ROWS = 2**(NVARS-1);

    // One fold per row pair.
    for (genvar k = 0; k < ROWS; k++) begin : g_fold
        assign folded[2*k +: 2] = fold_pair(tt_bits[2*k], tt_bits[2*k+1]);
    end

endmodule

// File: rtl/mfc_residue_store.sv
// Module: holds the residue registers, written per row or all at once.
// Assumes a synchronous active-low reset; a table load outranks a row write.
module mfc_residue_store #(
    parameter int NVARS = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         tt_we,
    input  logic [2*(2**(NVARS-1))-1:0]  folded,
    input  logic                         cfg_we,
    input  logic [NVARS-2:0]             cfg_row,
    input  logic [1:0]                   cfg_code,
    output logic [2*(2**(NVARS-1))-1:0]  codes
);
    localparam int SEL_W = NVARS - 1;
    localparam int ROWS  = 2**SEL_W;

    for (genvar k = 0; k < ROWS; k++) begin : g_row
        // Per-row register: reset, table load, then addressed write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                codes[2*k +: 2] <= 2'b00;
            end else if (tt_we) begin
                codes[2*k +: 2] <= folded[2*k +: 2];
            end else if (cfg_we && (cfg_row == SEL_W'(k))) begin
                codes[2*k +: 2] <= cfg_code;
            end
        end

        // R4: a row write leaves the other rows untouched.
        p_row_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !tt_we && (cfg_row != SEL_W'(k))) |=> $stable(codes[2*k +: 2]));

        // R4: the addressed row takes the written code.
        p_row_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && !tt_we && (cfg_row == SEL_W'(k))) |=> (codes[2*k +: 2] == $past(cfg_code)));
    end

    // R1: reset clears every row.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (codes == '0));

    // R6: a table load beats a simultaneous row write.
    p_tt_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tt_we && cfg_we) |=> (codes == $past(folded)));

    // R7: no write, no change.
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!tt_we && !cfg_we) |=> $stable(codes));

endmodule

// File: rtl/mfc_row_mux.sv
// Module: the folded multiplexer; selects a row and evaluates its residue.
// Assumes vars_in[0] is the data variable and the upper bits index the row.
module mfc_row_mux #(
    parameter int NVARS = 4
) (
    input  logic [2*(2**(NVARS-1))-1:0] codes,
    input  logic [NVARS-1:0]            vars_in,
    output logic                        f_out
);
    import mfc_pkg::*;

    localparam int SEL_W = NVARS - 1;

    logic [SEL_W-1:0] row_sel;
    logic [1:0]       row_code;

    // Pick the row by the select variables and resolve its residue.
    always_comb begin
        row_sel  = vars_in[NVARS-1:1];
        row_code = codes[2*row_sel +: 2];
        f_out    = eval_residue(row_code, vars_in[0]);
    end

endmodule

// File: rtl/mux_fn_cell.sv
// Module: top of the function cell; wires fold, store and multiplexer.
// Assumes 2 <= NVARS <= 6; output is combinational from vars_in once configured.
module mux_fn_cell #(
    parameter int NVARS = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [NVARS-2:0]        cfg_row,
    input  logic [1:0]              cfg_code,
    input  logic                    tt_we,
    input  logic [(2**NVARS)-1:0]   tt_bits,
    input  logic [NVARS-1:0]        vars_in,
    output logic                    f_out
);
    import mfc_pkg::*;

    localparam int SEL_W = NVARS - 1;
    localparam int ROWS  = 2**SEL_W;
    localparam int TT_W  = 2**NVARS;

    if (NVARS < 2 || NVARS > 6) begin : g_bad_nvars
        $error("mux_fn_cell: NVARS must be 2..6");
    end

    logic [2*ROWS-1:0] folded;
    logic [2*ROWS-1:0] codes;

    mfc_tt_fold #(.NVARS(NVARS)) i_fold (
        .tt_bits (tt_bits),
        .folded  (folded)
    );

    mfc_residue_store #(.NVARS(NVARS)) i_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .tt_we    (tt_we),
        .folded   (folded),
        .cfg_we   (cfg_we),
        .cfg_row  (cfg_row),
        .cfg_code (cfg_code),
        .codes    (codes)
    );

    mfc_row_mux #(.NVARS(NVARS)) i_mux (
        .codes   (codes),
        .vars_in (vars_in),
        .f_out   (f_out)
    );

    logic [SEL_W-1:0] chk_sel;
    logic [1:0]       chk_code;

    // Observe the stored code the multiplexer should be using.
    always_comb begin
        chk_sel  = vars_in[NVARS-1:1];
        chk_code = codes[2*chk_sel +: 2];
    end

    // R3: a data-variable residue passes vars_in[0].
    p_data_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_code == RES_DATA) |-> (f_out == vars_in[0]));

    // R3: an inverted residue passes ~vars_in[0].
    p_data_inv_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_code == RES_DATA_N) |-> (f_out != vars_in[0]));

    // R5: after a table load the output matches the table at the minterm.
    p_tt_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tt_we |=> (f_out == |(($past(tt_bits) >> vars_in) & TT_W'(1))));

endmodule

// File: tb/test_mux_fn_cell.sv
module test_mux_fn_cell;

    localparam int NV   = 4;
    localparam int ROWS = 2**(NV-1);
    localparam int TTW  = 2**NV;

    localparam int NTT = 6;
    localparam logic [TTW-1:0] TT_VEC [NTT] = '{
        16'h6996, 16'h8001, 16'hFFFF, 16'h0000, 16'hA5C3, 16'h1234
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [NV-2:0] cfg_row = '0;
    logic [1:0] cfg_code = 2'b00;
    logic tt_we = 1'b0;
    logic [TTW-1:0] tt_bits = '0;
    logic [NV-1:0] vars_in = '0;
    logic f_out;

    logic tt3_we = 1'b0;
    logic [7:0] tt3_bits = '0;
    logic [2:0] vars3 = '0;
    logic f3;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [1:0] exp_code [ROWS];

    always #2 clk = ~clk;

    mux_fn_cell #(.NVARS(NV)) i_mux_fn_cell (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_row(cfg_row),
        .cfg_code(cfg_code), .tt_we(tt_we), .tt_bits(tt_bits),
        .vars_in(vars_in), .f_out(f_out)
    );

    mux_fn_cell #(.NVARS(3)) i_mux_fn_cell3 (
        .clk(clk), .rst_n(rst_n), .cfg_we(1'b0), .cfg_row(2'b00),
        .cfg_code(2'b00), .tt_we(tt3_we), .tt_bits(tt3_bits),
        .vars_in(vars3), .f_out(f3)
    );

    task automatic check(input logic got, input logic exp, input string req, input int idx);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s minterm %0d: got %b expected %b", req, idx, got, exp);
        end
    endtask

    function automatic logic [1:0] model_fold(input logic a0, input logic a1);
        if (!a0 && !a1) return 2'b00;
        if (a0 && a1)   return 2'b01;
        if (!a0 && a1)  return 2'b10;
        return 2'b11;
    endfunction

    function automatic logic model_eval(input logic [1:0] c, input logic d);
        if (c == 2'b00) return 1'b0;
        if (c == 2'b01) return 1'b1;
        if (c == 2'b10) return d;
        return ~d;
    endfunction

    task automatic sweep_model(input string req);
        for (int m = 0; m < TTW; m++) begin
            vars_in = NV'(m);
            #0.5;
            check(f_out, model_eval(exp_code[m >> 1], m[0]), req, m);
        end
    endtask

    task automatic sweep_tt(input logic [TTW-1:0] tt, input string req);
        for (int m = 0; m < TTW; m++) begin
            vars_in = NV'(m);
            #0.5;
            check(f_out, tt[m], req, m);
        end
    endtask

    task automatic load_tt(input logic [TTW-1:0] tt, input bit with_cfg);
        @(negedge clk);
        tt_bits = tt;
        tt_we = 1'b1;
        if (with_cfg) begin
            cfg_we = 1'b1;
            cfg_row = 3'd3;
            cfg_code = 2'b01;
        end
        @(negedge clk);
        tt_we = 1'b0;
        cfg_we = 1'b0;
        for (int k = 0; k < ROWS; k++) exp_code[k] = model_fold(tt[2*k], tt[2*k+1]);
    endtask

    task automatic write_row(input int row, input logic [1:0] code);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_row = (NV-1)'(row);
        cfg_code = code;
        @(negedge clk);
        cfg_we = 1'b0;
        exp_code[row] = code;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int k = 0; k < ROWS; k++) exp_code[k] = 2'b00;
    endtask

    initial begin
        for (int k = 0; k < ROWS; k++) exp_code[k] = 2'b00;
        do_reset();
        // R1: reset state, every minterm 0
        sweep_model("R1 reset");

        // R5/R2: table walk, output equals tt_bits[vars_in]
        for (int t = 0; t < NTT; t++) begin
            load_tt(TT_VEC[t], 1'b0);
            sweep_tt(TT_VEC[t], "R5 table load");
        end

        // R1: reset after a load of all ones clears every row
        load_tt(16'hFFFF, 1'b0);
        do_reset();
        sweep_model("R1 reset after load");

        // R4/R3: single-row writes of every code
        write_row(5, 2'b10);
        sweep_model("R4 row write data");
        write_row(2, 2'b01);
        write_row(7, 2'b11);
        write_row(0, 2'b10);
        sweep_model("R3 residue codes");
        write_row(5, 2'b00);
        sweep_model("R4 row overwrite");

        // R6: table load and row write together, table wins
        load_tt(16'h0F0F, 1'b1);
        sweep_tt(16'h0F0F, "R6 table priority");

        // R7: idle cycles keep the residues
        load_tt(16'h5AC3, 1'b0);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            vars_in = NV'(i * 3);
        end
        sweep_tt(16'h5AC3, "R7 hold and combinational");

        // R2: worked three-variable example m0+m2+m6+m7
        @(negedge clk);
        tt3_bits = 8'hC5;
        tt3_we = 1'b1;
        @(negedge clk);
        tt3_we = 1'b0;
        for (int m = 0; m < 8; m++) begin
            logic [7:0] expv;
            expv = 8'b1100_0101;
            vars3 = 3'(m);
            #0.5;
            check(f3, expv[m], "R2 three-variable example", m);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

endmodule